// File: doc/BRIEF.md
# Direct-Mapped Second-Level Cache Tag Lookup Controller

This block runs the tag store of a direct-mapped second-level cache that sits on a processor bus. When it sees a bus transaction start, it captures the line address and the transaction kind. It drives the line index onto the tag RAM and compares the stored tag and valid bit with the requested tag. After a programmable number of clocks it reports the result on a one-cycle `hit_vld` pulse with the `hit` flag. On a miss that should allocate, it writes the new tag through a single-cycle write strobe and raises a line-fill request pulse for the external data path.

Static configuration inputs set five things: the hit latency; whether the tag RAM is synchronous or asynchronous, which decides whether write data is held one clock after the strobe falls; an initialisation mode in which every transaction clears the indexed entry; whether ownership-read misses allocate; and whether the valid line stays driven while tags are read. The valid line is modelled as a value output plus an enable output, so that the tri-state behaviour is visible at the ports. All configuration is sampled when a transaction is accepted. A start that arrives while the block is busy is dropped.

Top module: `l2tag_ctrl`

## Requirements
- R1: After reset `busy`, `hit_vld`, `hit`, `fill_req` and `tag_we` are 0 and `tag_valid_oe` is 1.
- R2: A start accepted at clock edge E produces exactly one `hit_vld` pulse, visible in the cycle after edge E+d. The value of d comes from `cfg_hit_dly`: 01 gives 1, 10 gives 2, 11 gives 3, and the reserved code 00 gives 3.
- R3: `hit` is 1 in the reporting cycle exactly when the indexed entry is valid, its tag equals the requested tag, and invalidate mode is off. A hit writes nothing.
- R4: A miss on kind READ (`bus_kind`=00) writes the requested tag with valid=1 and dirty=0. The write uses a `tag_we` pulse of one cycle in the reporting cycle, and `fill_req` pulses in the same cycle.
- R5: A miss on kind OWN (read with intent to modify, `bus_kind`=01) acts like R4 when `cfg_own_nofill`=0. When `cfg_own_nofill`=1 it writes nothing and requests no fill.
- R6: With `cfg_inv_all`=1, every transaction of any kind writes the indexed entry with valid=0 in the reporting cycle. `hit` and `fill_req` stay 0.
- R7: With `cfg_async_hold`=0, in the cycle after `tag_we` falls, `tag_wr_tag` and `tag_valid_o` return to 0 and `busy` is 0.
- R8: With `cfg_async_hold`=1, `tag_wr_tag` and `tag_valid_o` keep the written values for one cycle after `tag_we` falls, and `busy` stays 1 during that cycle.
- R9: `tag_valid_oe` is 0 during the lookup cycles (from acceptance up to the report) only when `cfg_async_hold`=1 and `cfg_fast_cast`=0. In every other case, and always during a write, it is 1.
- R10: A `bus_start` while `busy`=1 is ignored. It produces no report, no write and no fill.
- R11: A miss on kind WRITE (10) or OTHER (11), with invalidate mode off, writes nothing and requests no fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hit_dly | input | 2 | Hit latency select (00 treated as 3) |
| cfg_async_hold | input | 1 | 1: asynchronous tag RAM, hold write data one extra clock |
| cfg_inv_all | input | 1 | 1: every transaction invalidates the indexed entry |
| cfg_own_nofill | input | 1 | 1: ownership-read misses do not allocate |
| cfg_fast_cast | input | 1 | 1: keep the valid line driven during lookups |
| bus_start | input | 1 | Transaction start strobe |
| bus_line | input | TAG_W+IDX_W | Line address: tag in the upper bits, index in the lower bits |
| bus_kind | input | 2 | 00 READ, 01 OWN, 10 WRITE, 11 OTHER |
| busy | output | 1 | Lookup or tag write in progress |
| hit_vld | output | 1 | One-cycle result strobe |
| hit | output | 1 | Lookup result, qualified by hit_vld |
| fill_req | output | 1 | One-cycle line-fill request |
| tag_idx | output | IDX_W | Tag RAM index |
| tag_rd_tag | input | TAG_W | Stored tag read from the tag RAM |
| tag_rd_valid | input | 1 | Stored valid bit read from the tag RAM |
| tag_we | output | 1 | Tag RAM write strobe, active high |
| tag_wr_tag | output | TAG_W | Tag value to write |
| tag_valid_o | output | 1 | Valid bit value driven on the valid line |
| tag_valid_oe | output | 1 | Output enable of the valid line |
| tag_dirty_o | output | 1 | Dirty bit value to write (always clear) |

## Verification
The bench counts cycles from the posedge on which a start is accepted. The report, and any write and fill, must appear d edges later: the bench samples at the falling edge of that cycle and accepts nothing in any other cycle. The release or hold of the write data is checked one falling edge after the strobe. The valid-line enable is checked on every falling edge in the window from the acceptance edge up to the report edge. Each issued transaction queues one expected item that carries its due cycle. The monitor pops that item on the report, so a late, missing or extra report causes a mismatch or an empty-queue pop.

// File: rtl/l2tag_pkg.sv
// l2tag_pkg: shared types and helpers for the L2 tag lookup controller.
// Assumes: 2-bit transaction kind encoding fixed by the bus side.
package l2tag_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_OWN   = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_OTHER = 2'b11
    } bus_kind_e;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'b00,
        WR_STROBE = 2'b01,
        WR_HOLD   = 2'b10
    } wr_state_e;

    typedef struct packed {
        logic inv_all;
        logic own_nofill;
        logic async_hold;
        logic fast_cast;
    } cfg_t;

    // Map the latency select to a clock count; the reserved code runs as 3.
    function automatic logic [1:0] eff_delay(input logic [1:0] sel);
        return (sel == 2'b00) ? 2'd3 : sel;
    endfunction

endpackage

// File: rtl/l2tag_lat_timer.sv
// l2tag_lat_timer: counts the programmed hit latency after a lookup starts.
// Assumes: load is never raised while running (the top gates it with busy).
module l2tag_lat_timer
    import l2tag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] dly_sel,
    output logic       running,
    output logic       expire
);

    logic [1:0] cnt_q;
    logic       run_q;

    // Count down from latency-1; drop running on the expiry edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= eff_delay(dly_sel) - 2'd1;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == 2'd0) run_q <= 1'b0;
            else               cnt_q <= cnt_q - 2'd1;
        end
    end

    assign running = run_q;
    assign expire  = run_q && (cnt_q == 2'd0);

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire); // R2
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !load); // R10

endmodule

// File: rtl/l2tag_judge.sv
// l2tag_judge: compares the stored tag and decides report, write and fill.
// Assumes: tag RAM read data is valid for the latched index at expiry.
module l2tag_judge
    import l2tag_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             rd_valid,
    input  bus_kind_e        kind,
    input  cfg_t             cfg,
    output logic             hit,
    output logic             do_write,
    output logic             new_valid,
    output logic             do_fill
);

    logic match;
    logic alloc_kind;

    // Decide the lookup outcome from the compare and the configuration.
    always_comb begin
        match      = rd_valid && (rd_tag == req_tag);
        alloc_kind = (kind == KIND_READ) || ((kind == KIND_OWN) && !cfg.own_nofill);
        hit        = match && !cfg.inv_all;
        do_fill    = !cfg.inv_all && !match && alloc_kind;
        do_write   = cfg.inv_all || do_fill;
        new_valid  = do_fill;
    end

endmodule

// File: rtl/l2tag_wr_strobe.sv
// l2tag_wr_strobe: issues the one-cycle tag write strobe and, for an
// asynchronous tag RAM, holds the write data one clock after it falls.
// Assumes: go only arrives while idle.
module l2tag_wr_strobe
    import l2tag_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             hold_mode,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             valid_in,
    output logic             tag_we,
    output logic [TAG_W-1:0] wr_tag,
    output logic             valid_o,
    output logic             active
);

    wr_state_e        st_q;
    logic             hold_q;
    logic [TAG_W-1:0] tag_q;
    logic             val_q;

    // Sequence strobe, optional hold cycle, then release of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WR_IDLE;
            hold_q <= 1'b0;
            tag_q  <= '0;
            val_q  <= 1'b0;
        end else begin
            case (st_q)
                WR_IDLE: if (go) begin
                    st_q   <= WR_STROBE;
                    hold_q <= hold_mode;
                    tag_q  <= tag_in;
                    val_q  <= valid_in;
                end
                WR_STROBE: if (hold_q) begin
                    st_q <= WR_HOLD;
                end else begin
                    st_q  <= WR_IDLE;
                    tag_q <= '0;
                    val_q <= 1'b0;
                end
                default: begin
                    st_q  <= WR_IDLE;
                    tag_q <= '0;
                    val_q <= 1'b0;
                end
            endcase
        end
    end

    assign tag_we  = (st_q == WR_STROBE);
    assign active  = (st_q != WR_IDLE);
    assign wr_tag  = tag_q;
    assign valid_o = val_q;

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |=> !tag_we); // R4
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tag_we) && hold_q) |-> ($stable(wr_tag) && $stable(valid_o) && active)); // R8
    AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tag_we) && !hold_q) |-> (!active && wr_tag == '0 && !valid_o)); // R7

endmodule

// File: rtl/l2tag_ctrl.sv
// l2tag_ctrl: top of the direct-mapped L2 tag lookup controller. Accepts a
// bus start when idle, times the hit report, and drives tag writes.
// Assumes: tag RAM read data follows tag_idx within the lookup window.
module l2tag_ctrl
    import l2tag_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int IDX_W = 6,
    localparam int LINE_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_hit_dly,
    input  logic              cfg_async_hold,
    input  logic              cfg_inv_all,
    input  logic              cfg_own_nofill,
    input  logic              cfg_fast_cast,
    input  logic              bus_start,
    input  logic [LINE_W-1:0] bus_line,
    input  logic [1:0]        bus_kind,
    output logic              busy,
    output logic              hit_vld,
    output logic              hit,
    output logic              fill_req,
    output logic [IDX_W-1:0]  tag_idx,
    input  logic [TAG_W-1:0]  tag_rd_tag,
    input  logic              tag_rd_valid,
    output logic              tag_we,
    output logic [TAG_W-1:0]  tag_wr_tag,
    output logic              tag_valid_o,
    output logic              tag_valid_oe,
    output logic              tag_dirty_o
);

    logic             accept;
    logic             t_running;
    logic             t_expire;
    logic             s_active;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    bus_kind_e        kind_q;
    cfg_t             cfg_q;
    logic             hit_vld_q;
    logic             hit_q;
    logic             fill_q;
    logic             j_hit;
    logic             j_write;
    logic             j_valid;
    logic             j_fill;

    assign busy   = t_running || s_active;
    assign accept = bus_start && !busy;

    // Capture address, kind and configuration for the accepted transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            tag_q  <= '0;
            kind_q <= KIND_READ;
            cfg_q  <= '0;
        end else if (accept) begin
            idx_q  <= bus_line[IDX_W-1:0];
            tag_q  <= bus_line[LINE_W-1:IDX_W];
            kind_q <= bus_kind_e'(bus_kind);
            cfg_q  <= '{inv_all: cfg_inv_all, own_nofill: cfg_own_nofill,
                        async_hold: cfg_async_hold, fast_cast: cfg_fast_cast};
        end
    end

    l2tag_lat_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .dly_sel (cfg_hit_dly),
        .running (t_running),
        .expire  (t_expire)
    );

    l2tag_judge #(.TAG_W(TAG_W)) u_judge (
        .req_tag   (tag_q),
        .rd_tag    (tag_rd_tag),
        .rd_valid  (tag_rd_valid),
        .kind      (kind_q),
        .cfg       (cfg_q),
        .hit       (j_hit),
        .do_write  (j_write),
        .new_valid (j_valid),
        .do_fill   (j_fill)
    );

    // Register the one-cycle report and fill request at latency expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_vld_q <= 1'b0;
            hit_q     <= 1'b0;
            fill_q    <= 1'b0;
        end else begin
            hit_vld_q <= t_expire;
            hit_q     <= t_expire && j_hit;
            fill_q    <= t_expire && j_fill;
        end
    end

    l2tag_wr_strobe #(.TAG_W(TAG_W)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (t_expire && j_write),
        .hold_mode (cfg_q.async_hold),
        .tag_in    (tag_q),
        .valid_in  (j_valid),
        .tag_we    (tag_we),
        .wr_tag    (tag_wr_tag),
        .valid_o   (tag_valid_o),
        .active    (s_active)
    );

    assign hit_vld      = hit_vld_q;
    assign hit          = hit_q;
    assign fill_req     = fill_q;
    assign tag_idx      = idx_q;
    assign tag_dirty_o  = 1'b0;
    assign tag_valid_oe = !(t_running && cfg_q.async_hold && !cfg_q.fast_cast);

    AST_HIT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_vld); // R3
    AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (hit_vld && !hit && tag_we && tag_valid_o)); // R4
    AST_WE_WITH_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> hit_vld); // R4
    AST_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> tag_valid_oe); // R9
    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_we && cfg_q.inv_all) |-> (!tag_valid_o && !hit && !fill_req)); // R6

endmodule

// File: tb/l2tag_ctrl_tb.sv
`timescale 1ns/1ps
module l2tag_ctrl_tb;

    localparam int TAG_W = 5;
    localparam int IDX_W = 6;
    localparam int LINE_W = TAG_W + IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] cfg_hit_dly;
    logic cfg_async_hold, cfg_inv_all, cfg_own_nofill, cfg_fast_cast;
    logic bus_start;
    logic [LINE_W-1:0] bus_line;
    logic [1:0] bus_kind;
    logic busy, hit_vld, hit, fill_req;
    logic [IDX_W-1:0] tag_idx;
    logic [TAG_W-1:0] tag_rd_tag;
    logic tag_rd_valid;
    logic tag_we;
    logic [TAG_W-1:0] tag_wr_tag;
    logic tag_valid_o, tag_valid_oe, tag_dirty_o;

    always #2.5 clk = ~clk;

    l2tag_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_hit_dly(cfg_hit_dly),
        .cfg_async_hold(cfg_async_hold), .cfg_inv_all(cfg_inv_all),
        .cfg_own_nofill(cfg_own_nofill), .cfg_fast_cast(cfg_fast_cast),
        .bus_start(bus_start), .bus_line(bus_line), .bus_kind(bus_kind),
        .busy(busy), .hit_vld(hit_vld), .hit(hit), .fill_req(fill_req),
        .tag_idx(tag_idx), .tag_rd_tag(tag_rd_tag), .tag_rd_valid(tag_rd_valid),
        .tag_we(tag_we), .tag_wr_tag(tag_wr_tag), .tag_valid_o(tag_valid_o),
        .tag_valid_oe(tag_valid_oe), .tag_dirty_o(tag_dirty_o)
    );

    // Tag RAM model driven only by the DUT ports.
    logic [TAG_W-1:0] mem_tag [DEPTH];
    logic             mem_val [DEPTH];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_tag[i] <= '0;
                mem_val[i] <= 1'b0;
            end
        end else if (tag_we) begin
            mem_tag[tag_idx] <= tag_wr_tag;
            mem_val[tag_idx] <= tag_valid_o;
        end
    end
    assign tag_rd_tag   = mem_tag[tag_idx];
    assign tag_rd_valid = mem_val[tag_idx];

    // Reference shadow of the tag store.
    logic [TAG_W-1:0] sh_tag [DEPTH];
    logic             sh_val [DEPTH];

    typedef struct {
        int               due;
        bit               hit;
        bit               fill;
        bit               wr;
        logic [TAG_W-1:0] wtag;
        bit               wval;
        bit               hold;
        string            req;
    } exp_t;
    exp_t exp_q [$];

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int look_lo = 0, look_hi = -1;
    bit look_oe = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected items on each report and checks the write tail.
    bit               pend = 1'b0;
    bit               pend_hold;
    logic [TAG_W-1:0] pend_tag;
    bit               pend_val;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (pend) begin
                pend = 1'b0;
                if (pend_hold) begin
                    check(!tag_we && busy && tag_wr_tag == pend_tag && tag_valid_o == pend_val,
                          "R8", "held write data", {tag_wr_tag, tag_valid_o}, {pend_tag, pend_val});
                end else begin
                    check(!tag_we && !busy && tag_wr_tag == '0 && !tag_valid_o,
                          "R7", "released write data", {busy, tag_wr_tag, tag_valid_o}, 0);
                end
            end
            if (cyc >= look_lo && cyc <= look_hi)
                check(tag_valid_oe == look_oe, "R9", "valid line enable in lookup",
                      tag_valid_oe, look_oe);
            if (hit_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected report", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.due, "R2", "report cycle", cyc, e.due);
                    check(hit == e.hit, e.req, "hit", hit, e.hit);
                    check(fill_req == e.fill, e.req, "fill_req", fill_req, e.fill);
                    check(tag_we == e.wr, e.req, "tag_we", tag_we, e.wr);
                    if (e.wr) begin
                        check(tag_wr_tag == e.wtag && tag_valid_o == e.wval && !tag_dirty_o,
                              e.req, "written tag/valid", {tag_wr_tag, tag_valid_o},
                              {e.wtag, e.wval});
                        pend      = 1'b1;
                        pend_hold = e.hold;
                        pend_tag  = e.wtag;
                        pend_val  = e.wval;
                    end
                end
            end else if (tag_we || fill_req) begin
                check(1'b0, "R10", "write or fill without report", {tag_we, fill_req}, 0);
            end
        end
    end

    // Driver: computes the expected outcome and starts one transaction.
    task automatic issue(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] ix,
                         input logic [1:0] k, input string req);
        exp_t e;
        int d;
        bit match;
        while (busy) @(negedge clk);
        d = (cfg_hit_dly == 2'b00) ? 3 : int'(cfg_hit_dly);
        match = sh_val[ix] && sh_tag[ix] == t;
        e.hit  = match && !cfg_inv_all;
        e.fill = !cfg_inv_all && !match &&
                 (k == 2'b00 || (k == 2'b01 && !cfg_own_nofill));
        e.wr   = cfg_inv_all || e.fill;
        e.wtag = t;
        e.wval = e.fill;
        e.hold = cfg_async_hold;
        e.due  = cyc + 1 + d;
        e.req  = req;
        if (e.wr) begin
            sh_tag[ix] = t;
            sh_val[ix] = e.wval;
        end
        exp_q.push_back(e);
        look_lo = cyc + 1;
        look_hi = cyc + d;
        look_oe = !(cfg_async_hold && !cfg_fast_cast);
        bus_line  = {t, ix};
        bus_kind  = k;
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    task automatic settle(input string req);
        int n = 0;
        while ((busy || exp_q.size() != 0) && n < 50) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, req, "pending expected reports", exp_q.size(), 0);
    endtask

    task automatic run(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] ix,
                       input logic [1:0] k, input string req);
        issue(t, ix, k, req);
        settle(req);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            sh_tag[i] = '0;
            sh_val[i] = 1'b0;
        end
        rst_n = 1'b0;
        cfg_hit_dly = 2'b01;
        cfg_async_hold = 1'b0;
        cfg_inv_all = 1'b0;
        cfg_own_nofill = 1'b0;
        cfg_fast_cast = 1'b0;
        bus_start = 1'b0;
        bus_line = '0;
        bus_kind = 2'b00;
        repeat (3) @(negedge clk);
        check(!busy && !hit_vld && !hit && !fill_req && !tag_we && tag_valid_oe,
              "R1", "reset outputs", {busy, hit_vld, hit, fill_req, tag_we, tag_valid_oe}, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R11 with latency 1
        run(5'd3, 6'd5, 2'b00, "R4");
        run(5'd3, 6'd5, 2'b00, "R3");
        run(5'd9, 6'd5, 2'b00, "R4");
        run(5'd7, 6'd20, 2'b10, "R11");
        run(5'd7, 6'd21, 2'b11, "R11");
        run(5'd9, 6'd5, 2'b11, "R3");
        // R2 other latencies, reserved code
        cfg_hit_dly = 2'b10;  run(5'd1, 6'd30, 2'b00, "R2");
        cfg_hit_dly = 2'b11;  run(5'd1, 6'd30, 2'b00, "R2");
        cfg_hit_dly = 2'b00;  run(5'd2, 6'd31, 2'b00, "R2");
        run(5'd2, 6'd31, 2'b00, "R2");
        // R5 ownership reads
        cfg_hit_dly = 2'b01;
        run(5'd4, 6'd40, 2'b01, "R5");
        cfg_own_nofill = 1'b1;
        run(5'd6, 6'd41, 2'b01, "R5");
        check(mem_val[41] == 1'b0, "R5", "entry untouched by no-fill miss", mem_val[41], 0);
        run(5'd6, 6'd41, 2'b00, "R5");
        cfg_own_nofill = 1'b0;
        // R6 invalidate mode on several kinds
        cfg_inv_all = 1'b1;
        run(5'd3, 6'd5, 2'b00, "R6");
        run(5'd4, 6'd40, 2'b10, "R6");
        run(5'd0, 6'd0, 2'b11, "R6");
        cfg_inv_all = 1'b0;
        run(5'd3, 6'd5, 2'b00, "R6");
        // R8 R9 async hold, tri-state lookup
        cfg_async_hold = 1'b1;
        cfg_hit_dly = 2'b11;
        run(5'd12, 6'd50, 2'b00, "R8");
        run(5'd12, 6'd50, 2'b00, "R9");
        cfg_fast_cast = 1'b1;
        run(5'd13, 6'd51, 2'b00, "R9");
        cfg_async_hold = 1'b0;
        cfg_fast_cast = 1'b0;
        run(5'd14, 6'd52, 2'b00, "R7");
        // R10 start while busy is dropped
        issue(5'd1, 6'd10, 2'b00, "R10");
        bus_line = {5'd2, 6'd11};
        bus_kind = 2'b00;
        bus_start = 1'b1;
        repeat (2) @(negedge clk);
        bus_start = 1'b0;
        settle("R10");
        check(mem_val[11] == 1'b0, "R10", "ignored start wrote entry", mem_val[11], 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule